// File: doc/BRIEF.md
# Octet-to-Word Cell Receive Packer

This block sits on the receive side of a cell link. Octets arrive one per beat on an 8-bit bus, qualified by a valid strobe, and a start-of-cell strobe marks the first octet of each cell. The packer gathers each group of four octets into a 32-bit word and presents it on a core-side bus with a one-cycle word-valid pulse. It also raises a marker on the word that carries a cell's first octet. The earliest octet of a word always occupies the most significant byte.

A register port holds the cell length in octets. The length is a multiple of four between 4 and 124, so a cell always fills a whole number of words. When a cell has delivered its programmed number of octets, the block waits for the next start-of-cell strobe and discards any octets in between. A start-of-cell that arrives while a cell is still incomplete is a short-cell violation. The block sets a sticky flag, drops the partly built word, and starts the new cell from the top byte. Software clears the flag by writing a one to it.

Top module: `cell_octet_packer`

## Requirements
- R1: Within a word, the octets are placed in arrival order from the top byte down: 1st in word_data[31:24], 2nd in [23:16], 3rd in [15:8], 4th in [7:0].
- R2: An accepted octet with in_soc high always lands in word_data[31:24] of a new word. word_soc is high only together with word_valid, and only for the first word of each cell.
- R3: word_valid pulses for one cycle on the clock edge after every fourth accepted octet. Beats with in_valid low are ignored and do not break up a word.
- R4: A cell ends after cfg_size accepted octets. Until the next in_soc, octets with in_soc low are dropped and produce no word.
- R5: A write with cfg_we=1 and cfg_addr=0 loads cfg_wdata into cfg_size only when the value is a nonzero multiple of 4 no greater than 124. Any other value leaves cfg_size unchanged.
- R6: An accepted in_soc that arrives while a cell has received at least one octet but fewer than cfg_size octets sets viol_flag on the next edge. The unfinished word is dropped, and the new cell is packed normally.
- R7: viol_flag stays set until a write with cfg_we=1, cfg_addr=1 and cfg_wdata[0]=1 clears it. If a violation occurs in the same cycle as the clear, the flag stays set.
- R8: After a synchronous reset, cfg_size is 8, viol_flag is 0, word_valid is 0, and no cell is in progress.
- R9: An in_soc that arrives right after a cell has completed does not set viol_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Octet beat valid |
| in_soc | input | 1 | Start-of-cell, high with a cell's first octet |
| in_octet | input | 8 | Received octet |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0: cell size, 1: flag clear |
| cfg_wdata | input | 8 | Register write data |
| word_valid | output | 1 | One-cycle pulse per packed word |
| word_data | output | 32 | Packed word, earliest octet in bits 31:24 |
| word_soc | output | 1 | High with the first word of a cell |
| viol_flag | output | 1 | Sticky short-cell violation flag |
| cfg_size | output | 7 | Programmed cell length in octets |

## Verification
The bench sweeps every legal cell length from 4 to 124, some of them with idle beats inserted. A design that counted cells wrongly would emit the wrong number of words, and one that let idle beats break a word would deliver misaligned bytes. It sends octets with no start-of-cell after a complete cell, which a design that kept packing would turn into spurious words. It cuts a cell short and checks that the flag is set and that the next cell starts in the top byte, which catches a packer that keeps its stale byte lane. It also writes illegal sizes, clears the flag in the same cycle as a violation, and starts cells back to back, which catch a loose size check, a clear that wins over a set, and a false violation at a cell boundary.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  localparam int OCT_W    = 8;
  localparam int LANES    = 4;
  localparam int MAX_CELL = 124;
  localparam int DEF_CELL = 8;
  localparam int SIZE_W   = $clog2(MAX_CELL + 1);
  localparam int WORD_W   = OCT_W * LANES;

  localparam logic CFG_SIZE  = 1'b0;
  localparam logic CFG_CLEAR = 1'b1;
endpackage

// File: rtl/cpk_cfg.sv
module cpk_cfg #(
  parameter int DATA_W   = 8,
  parameter int SIZE_W   = 7,
  parameter int LANES    = 4,
  parameter int MAX_CELL = 124,
  parameter int DEF_CELL = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              viol_pulse,
  output logic [SIZE_W-1:0] cell_size,
  output logic              viol_flag
);
  import cpk_pkg::*;

  logic size_ok;
  logic clr_hit;

  // Legal size: nonzero, a whole number of words, within range.
  always_comb begin
    size_ok = (cfg_wdata != '0) &&
              ((int'(cfg_wdata) % LANES) == 0) &&
              (int'(cfg_wdata) <= MAX_CELL);
    clr_hit = cfg_we && (cfg_addr == CFG_CLEAR) && cfg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_size <= SIZE_W'(DEF_CELL);
      viol_flag <= 1'b0;
    end else begin
      if (cfg_we && (cfg_addr == CFG_SIZE) && size_ok)
        cell_size <= cfg_wdata[SIZE_W-1:0];
      // A new violation takes priority over a clear in the same cycle.
      if (viol_pulse)
        viol_flag <= 1'b1;
      else if (clr_hit)
        viol_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cpk_tracker.sv
module cpk_tracker #(
  parameter int SIZE_W = 7,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_soc,
  input  logic [SIZE_W-1:0]        cell_size,
  output logic                     accept,
  output logic                     word_done,
  output logic                     first_word,
  output logic                     viol_pulse
);
  localparam int LANE_W = $clog2(LANES);

  logic [SIZE_W-1:0] cnt;
  logic              active;
  logic [SIZE_W-1:0] cur;
  logic [SIZE_W:0]   nxt;
  logic [LANE_W-1:0] lane;

  always_comb begin
    accept     = in_valid && (in_soc || active);
    cur        = in_soc ? '0 : cnt;
    lane       = cur[LANE_W-1:0];
    nxt        = {1'b0, cur} + 1'b1;
    word_done  = accept && (lane == LANE_W'(LANES - 1));
    first_word = (int'(cur) < LANES);
    // A nonzero count means a cell is open and has not reached its size.
    viol_pulse = in_valid && in_soc && (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (accept) begin
      if (nxt >= {1'b0, cell_size}) begin
        cnt    <= '0;
        active <= 1'b0;
      end else begin
        cnt    <= nxt[SIZE_W-1:0];
        active <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpk_assembler.sv
module cpk_assembler #(
  parameter int OCT_W = 8,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept,
  input  logic                   word_done,
  input  logic                   first_word,
  input  logic [OCT_W-1:0]       in_octet,
  output logic                   word_valid,
  output logic [OCT_W*LANES-1:0] word_data,
  output logic                   word_soc
);
  localparam int HOLD_W = OCT_W * (LANES - 1);

  // Holds the earlier octets of the current word, newest at the bottom.
  logic [HOLD_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold       <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_soc   <= 1'b0;
    end else begin
      word_valid <= word_done;
      word_soc   <= word_done && first_word;
      if (accept)
        hold <= {hold[HOLD_W-OCT_W-1:0], in_octet};
      if (word_done)
        word_data <= {hold, in_octet};
    end
  end
endmodule

// File: rtl/cell_octet_packer.sv
module cell_octet_packer
  import cpk_pkg::*;
#(
  parameter int OCT_W_P    = OCT_W,
  parameter int LANES_P    = LANES,
  parameter int MAX_CELL_P = MAX_CELL,
  parameter int DEF_CELL_P = DEF_CELL,
  parameter int SIZE_W_P   = SIZE_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_soc,
  input  logic [OCT_W_P-1:0]         in_octet,
  input  logic                       cfg_we,
  input  logic                       cfg_addr,
  input  logic [OCT_W_P-1:0]         cfg_wdata,
  output logic                       word_valid,
  output logic [OCT_W_P*LANES_P-1:0] word_data,
  output logic                       word_soc,
  output logic                       viol_flag,
  output logic [SIZE_W_P-1:0]        cfg_size
);
  logic accept, word_done, first_word, viol_pulse;

  cpk_cfg #(
    .DATA_W(OCT_W_P), .SIZE_W(SIZE_W_P), .LANES(LANES_P),
    .MAX_CELL(MAX_CELL_P), .DEF_CELL(DEF_CELL_P)
  ) i_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .viol_pulse(viol_pulse),
    .cell_size(cfg_size), .viol_flag(viol_flag)
  );

  cpk_tracker #(.SIZE_W(SIZE_W_P), .LANES(LANES_P)) i_trk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_soc(in_soc),
    .cell_size(cfg_size), .accept(accept), .word_done(word_done),
    .first_word(first_word), .viol_pulse(viol_pulse)
  );

  cpk_assembler #(.OCT_W(OCT_W_P), .LANES(LANES_P)) i_asm (
    .clk(clk), .rst(rst), .accept(accept), .word_done(word_done),
    .first_word(first_word), .in_octet(in_octet),
    .word_valid(word_valid), .word_data(word_data), .word_soc(word_soc)
  );
endmodule

// File: rtl/cell_octet_packer_chk.sv
module cell_octet_packer_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic       cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic       word_valid,
  input logic       word_soc,
  input logic       viol_flag,
  input logic [6:0] cfg_size
);
  assert_soc_with_word_R2: assert property (@(posedge clk) disable iff (rst)
    word_soc |-> word_valid);

  assert_word_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_size_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_size != 7'd0) && (cfg_size[1:0] == 2'b00) && (cfg_size <= 7'd124));

  assert_size_load_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_addr && cfg_wdata != 8'd0 && cfg_wdata[1:0] == 2'b00 &&
     cfg_wdata <= 8'd124) |=> (cfg_size == $past(cfg_wdata[6:0])));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && !(cfg_we && cfg_addr && cfg_wdata[0])) |=> viol_flag);

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (!word_valid && !viol_flag && cfg_size == 7'd8));
endmodule

bind cell_octet_packer cell_octet_packer_chk i_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .word_valid(word_valid), .word_soc(word_soc),
  .viol_flag(viol_flag), .cfg_size(cfg_size)
);

// File: tb/test_cell_octet_packer.sv
module test_cell_octet_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_soc = 1'b0;
  logic [7:0]  in_octet = '0;
  logic        cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        word_valid, word_soc, viol_flag;
  logic [31:0] word_data;
  logic [6:0]  cfg_size;

  int tests = 0, fails = 0;
  int nw = 0;
  logic [31:0] wd [64];
  logic        ws [64];

  always #4 clk = ~clk;

  cell_octet_packer i_cell_octet_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_soc(in_soc),
    .in_octet(in_octet), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .word_valid(word_valid), .word_data(word_data),
    .word_soc(word_soc), .viol_flag(viol_flag), .cfg_size(cfg_size)
  );

  always @(negedge clk) begin
    if (!rst && word_valid) begin
      if (nw < 64) begin
        wd[nw] = word_data;
        ws[nw] = word_soc;
      end
      nw = nw + 1;
    end
  end

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(logic v, logic s, logic [7:0] o);
    in_valid = v; in_soc = s; in_octet = o;
    @(negedge clk);
    in_valid = 1'b0; in_soc = 1'b0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Sends n octets starting with in_soc; optional idle beats in between.
  task automatic send_cell(int n, int seed, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 5 == 2)) beat(1'b0, 1'b0, 8'hEE);
      beat(1'b1, i == 0, pat(seed, i));
    end
  endtask

  task automatic flush();
    beat(1'b0, 1'b0, 8'h00);
    beat(1'b0, 1'b0, 8'h00);
  endtask

  // Checks the captured words against cell (seed) from word index w0.
  task automatic check_words(string req, int w0, int nwords, int seed);
    for (int w = 0; w < nwords; w++) begin
      check(req, int'(wd[w0 + w]),
            int'({pat(seed, 4*w), pat(seed, 4*w+1), pat(seed, 4*w+2), pat(seed, 4*w+3)}));
      check("R2", int'(ws[w0 + w]), (w == 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 size", int'(cfg_size), 8);
    check("R8 flag", int'(viol_flag), 0);
    check("R8 valid", int'(word_valid), 0);
    // R8: no cell in progress, so octets without a start are dropped.
    nw = 0;
    for (int i = 0; i < 8; i++) beat(1'b1, 1'b0, 8'(i));
    flush();
    check("R8 idle drop", nw, 0);

    // R1 R3 R4: sweep every legal size, with and without idle beats.
    for (int sz = 4; sz <= 124; sz += 4) begin
      wr(1'b0, 8'(sz));
      check("R5 load", int'(cfg_size), sz);
      nw = 0;
      send_cell(sz, sz, (sz % 8) == 4);
      flush();
      check("R3 word count", nw, sz / 4);
      check_words("R1", 0, sz / 4, sz);
      // R4: trailing octets without in_soc are dropped.
      nw = 0;
      for (int i = 0; i < 6; i++) beat(1'b1, 1'b0, 8'hA5);
      flush();
      check("R4 drop", nw, 0);
      check("R9 no flag", int'(viol_flag), 0);
    end

    // R5: illegal writes are ignored.
    wr(1'b0, 8'd12);
    wr(1'b0, 8'd0);   check("R5 zero", int'(cfg_size), 12);
    wr(1'b0, 8'd6);   check("R5 odd", int'(cfg_size), 12);
    wr(1'b0, 8'd128); check("R5 big", int'(cfg_size), 12);
    wr(1'b0, 8'd200); check("R5 big2", int'(cfg_size), 12);

    // R9: back-to-back cells with no gap, no violation.
    wr(1'b0, 8'd8);
    nw = 0;
    send_cell(8, 1, 1'b0);
    send_cell(8, 2, 1'b0);
    flush();
    check("R9 count", nw, 4);
    check("R9 flag", int'(viol_flag), 0);
    check_words("R9", 0, 2, 1);
    check_words("R9", 2, 2, 2);

    // R6: short cell of 5 octets, then a full cell.
    nw = 0;
    send_cell(5, 3, 1'b0);
    check("R6 no flag yet", int'(viol_flag), 0);
    send_cell(8, 4, 1'b0);
    flush();
    check("R6 flag", int'(viol_flag), 1);
    check("R6 count", nw, 3);
    check_words("R6 first", 0, 1, 3);
    check_words("R6 realign", 1, 2, 4);

    // R7: sticky over idle time and writes of zero to the clear bit.
    flush();
    wr(1'b1, 8'h00);
    check("R7 sticky", int'(viol_flag), 1);
    wr(1'b1, 8'h01);
    check("R7 clear", int'(viol_flag), 0);

    // R7: a violation and a clear in the same cycle leave the flag set.
    beat(1'b1, 1'b1, 8'h10);
    beat(1'b1, 1'b0, 8'h11);
    cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'h01;
    beat(1'b1, 1'b1, 8'h20);
    cfg_we = 1'b0;
    check("R7 set wins", int'(viol_flag), 1);
    wr(1'b1, 8'h01);
    check("R7 clear2", int'(viol_flag), 0);

    // R6: a start on the very first octet of an open cell (count 1).
    beat(1'b1, 1'b0, 8'h21);
    flush();
    nw = 0;
    beat(1'b1, 1'b1, 8'h30);
    send_cell(8, 5, 1'b0);
    flush();
    check("R6 count1", int'(viol_flag), 1);
    check("R6 count1 words", nw, 2);
    check_words("R6 count1", 0, 2, 5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule